// File: doc/BRIEF.md
# Packed Byte Multiply-Accumulate Unit

This SIMD datapath takes two 128-bit operand vectors. One vector holds sixteen unsigned bytes and the other holds sixteen signed bytes. The datapath multiplies the bytes lane by lane. It adds each neighbouring pair of products and clamps every pair sum to the signed 16-bit range. The result is eight signed halfwords packed into one 128-bit word.

The execution stage of a vector pipeline uses the block as a single-cycle functional unit. It presents both operands together with a one-cycle strobe. One clock later the packed result appears, qualified by a valid flag. The two operands have fixed roles, so the unit is not commutative. The issuing logic must route the unsigned data and the signed coefficients to the correct buses.

Top module: `pbmac_top`

## Requirements
- R1: While rst_ni is low, and after reset until the first strobe, res_o is all zeros and valid_o is 0.
- R2: valid_o is 1 in the cycle after a clock edge where strobe_i was 1, and 0 in the cycle after an edge where strobe_i was 0.
- R3: Byte j of each operand occupies bits [8j+7:8j]. Every byte of ua_i is unsigned (0..255) and every byte of sb_i is two's-complement signed (-128..127).
- R4: Result lane k occupies res_o bits [16k+15:16k]. It equals ua[2k]*sb[2k] + ua[2k+1]*sb[2k+1], computed exactly, when that sum lies in -32768..32767.
- R5: A lane whose exact pair sum is above 32767 reads 32767 (0x7FFF).
- R6: A lane whose exact pair sum is below -32768 reads -32768 (0x8000).
- R7: res_o is captured only on clock edges where strobe_i is 1. Operand changes while strobe_i is 0 leave res_o unchanged.
- R8: The operand roles are fixed. With ua bytes 0x80 and sb bytes 0x01 every lane is 256. With the two buses swapped every lane is -256.
- R9: A strobe with ua_i all zeros, or with sb_i all zeros, yields res_o all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Operands valid this cycle; result is captured at the edge |
| ua_i | input | 128 | Sixteen unsigned bytes |
| sb_i | input | 128 | Sixteen signed bytes |
| res_o | output | 128 | Eight saturated signed 16-bit lanes |
| valid_o | output | 1 | Result valid, strobe delayed one cycle |

## Verification
The block holds no state apart from the result register and the valid flag, so a fault shows up one cycle after the strobe that exposes it. A wrong sign extension, lane pairing or product width gives a wrong value in a single lane, and only for operand values that reach the affected bit. For this reason lane 0 sweeps every unsigned/signed byte combination, and the other lanes carry skewed copies of the same sweep. A faulty clamp or a misplaced bit in the comparison becomes visible only at the extremes of the pair sum. A failure to hold the result, or a misaligned valid flag, shows on the cycle immediately after a strobe-low edge.

// File: rtl/pbmac_pkg.sv
package pbmac_pkg;
  localparam int unsigned DEF_BYTE_W    = 8;
  localparam int unsigned DEF_RES_W     = 16;
  localparam int unsigned DEF_RES_LANES = 8;
endpackage

// File: rtl/pbmac_mul.sv
// unsigned x signed byte product, exact in 2*IN_W+1 bits
module pbmac_mul #(
  parameter int unsigned IN_W = pbmac_pkg::DEF_BYTE_W,
  localparam int unsigned PW  = 2 * IN_W + 1
) (
  input  logic [IN_W-1:0]      u_i,
  input  logic [IN_W-1:0]      s_i,
  output logic signed [PW-1:0] prod_o
);
  logic signed [PW-1:0] u_ext, s_ext;

  always_comb begin
    u_ext  = signed'({{(PW-IN_W){1'b0}}, u_i});
    s_ext  = signed'({{(PW-IN_W){s_i[IN_W-1]}}, s_i});
    prod_o = u_ext * s_ext;
  end
endmodule

// File: rtl/pbmac_pair_sat.sv
// adds two products and clamps to signed OUT_W
module pbmac_pair_sat #(
  parameter int unsigned IN_W  = pbmac_pkg::DEF_BYTE_W,
  parameter int unsigned OUT_W = pbmac_pkg::DEF_RES_W,
  localparam int unsigned PW   = 2 * IN_W + 1,
  localparam int unsigned SW   = PW + 1
) (
  input  logic signed [PW-1:0] prod_a_i,
  input  logic signed [PW-1:0] prod_b_i,
  output logic [OUT_W-1:0]     lane_o
);
  localparam logic signed [SW-1:0] SAT_HI = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = {prod_a_i[PW-1], prod_a_i} + {prod_b_i[PW-1], prod_b_i};
    if (sum > SAT_HI)      lane_o = SAT_HI[OUT_W-1:0];
    else if (sum < SAT_LO) lane_o = SAT_LO[OUT_W-1:0];
    else                   lane_o = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/pbmac_top.sv
module pbmac_top #(
  parameter int unsigned IN_W      = pbmac_pkg::DEF_BYTE_W,
  parameter int unsigned OUT_W     = pbmac_pkg::DEF_RES_W,
  parameter int unsigned OUT_LANES = pbmac_pkg::DEF_RES_LANES,
  localparam int unsigned IN_LANES = 2 * OUT_LANES,
  localparam int unsigned VEC_W    = IN_LANES * IN_W,
  localparam int unsigned RES_W    = OUT_LANES * OUT_W,
  localparam int unsigned PW       = 2 * IN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [VEC_W-1:0] ua_i,
  input  logic [VEC_W-1:0] sb_i,
  output logic [RES_W-1:0] res_o,
  output logic             valid_o
);
  logic signed [PW-1:0] prod [IN_LANES];
  logic [RES_W-1:0]     res_nxt;

  for (genvar j = 0; j < IN_LANES; j++) begin : g_mul
    pbmac_mul #(.IN_W(IN_W)) mul_i (
      .u_i   (ua_i[j*IN_W +: IN_W]),
      .s_i   (sb_i[j*IN_W +: IN_W]),
      .prod_o(prod[j])
    );
  end

  for (genvar k = 0; k < OUT_LANES; k++) begin : g_pair
    pbmac_pair_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) sat_i (
      .prod_a_i(prod[2*k]),
      .prod_b_i(prod[2*k+1]),
      .lane_o  (res_nxt[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) res_o <= res_nxt;
    end
  end
endmodule

// File: rtl/pbmac_chk.sv
module pbmac_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned RES_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_i,
  input logic [VEC_W-1:0] ua_i,
  input logic [VEC_W-1:0] sb_i,
  input logic [RES_W-1:0] res_o,
  input logic             valid_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> (res_o == '0 && !valid_o));

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);

  // R2
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(res_o));

  // R9
  zero_ua_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && ua_i == '0) |=> res_o == '0);

  // R9
  zero_sb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && sb_i == '0) |=> res_o == '0);
endmodule

bind pbmac_top pbmac_chk #(.VEC_W(VEC_W), .RES_W(RES_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_i(strobe_i),
  .ua_i    (ua_i),
  .sb_i    (sb_i),
  .res_o   (res_o),
  .valid_o (valid_o)
);

// File: tb/pbmac_top_tb_top.sv
`timescale 1ns/1ps
module pbmac_top_tb_top;
  localparam int NL = 8;
  localparam int VW = 128;
  localparam int RW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          strobe_i = 1'b0;
  logic [VW-1:0] ua_i = '0;
  logic [VW-1:0] sb_i = '0;
  logic [RW-1:0] res_o;
  logic          valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pbmac_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .ua_i(ua_i), .sb_i(sb_i), .res_o(res_o), .valid_o(valid_o)
  );

  function automatic int raw_lane(logic [VW-1:0] u, logic [VW-1:0] s, int k);
    int acc = 0;
    for (int b = 2*k; b <= 2*k+1; b++) begin
      int uv = int'(u[8*b +: 8]);
      int sv = int'(s[8*b +: 8]);
      if (sv > 127) sv = sv - 256;
      acc += uv * sv;
    end
    return acc;
  endfunction

  function automatic int clamp16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int lane_val(int k);
    int v = int'(res_o[16*k +: 16]);
    if (v > 32767) v = v - 65536;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(logic [VW-1:0] u, logic [VW-1:0] s);
    check("R2", int'(valid_o), 1);
    for (int k = 0; k < NL; k++) begin
      int raw = raw_lane(u, s, k);
      string tag = (raw > 32767) ? "R5" : (raw < -32768) ? "R6" : "R4";
      check(tag, lane_val(k), clamp16(raw));
    end
  endtask

  task automatic fill(output logic [VW-1:0] v, input logic [7:0] b);
    for (int j = 0; j < 2*NL; j++) v[8*j +: 8] = b;
  endtask

  task automatic single(logic [VW-1:0] u, logic [VW-1:0] s, string req, int exp_all);
    @(negedge clk_i);
    ua_i = u; sb_i = s; strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
    for (int k = 0; k < NL; k++) check(req, lane_val(k), exp_all);
    check("R2", int'(valid_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, pu, ps;
    bit pend;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1", int'(res_o == '0), 1);
    check("R1", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(res_o == '0), 1);
    check("R1", int'(valid_o), 0);

    // R8 operand roles
    fill(a, 8'h80); fill(b, 8'h01);
    single(a, b, "R8", 256);
    single(b, a, "R8", -256);
    // R5 / R6 extremes
    fill(a, 8'hFF); fill(b, 8'h7F);
    single(a, b, "R5", 32767);
    fill(b, 8'h80);
    single(a, b, "R6", -32768);
    // R4 exact edge: 191*2 + 255*127 = 32767; R5 just over
    for (int k = 0; k < NL; k++) begin
      a[16*k +: 16] = {8'd191, 8'd255}; b[16*k +: 16] = {8'd2, 8'd127};
    end
    single(a, b, "R4", 32767);
    for (int k = 0; k < NL; k++) a[16*k+8 +: 8] = 8'd192;
    single(a, b, "R5", 32767);
    // R9 zero operands
    fill(b, 8'h9C);
    single('0, b, "R9", 0);
    fill(a, 8'hC3);
    single(a, '0, "R9", 0);

    // R7 hold with strobe low, R2 valid drop
    fill(a, 8'h10); fill(b, 8'h03);
    single(a, b, "R4", 96);
    for (int i = 0; i < 4; i++) begin
      ua_i = {4{32'hA5F0_1E77 + i}}; sb_i = {4{32'h8001_7F3C ^ i}};
      @(negedge clk_i);
      for (int k = 0; k < NL; k++) check("R7", lane_val(k), 96);
      check("R2", int'(valid_o), 0);
    end

    // R3/R4/R5/R6 sweep: lane 0 byte 0 covers every (u,s); others skewed
    pend = 1'b0;
    for (int u = 0; u < 256; u++) begin
      for (int s = 0; s < 256; s++) begin
        @(negedge clk_i);
        if (pend) check_vec(pu, ps);
        for (int j = 0; j < 2*NL; j++) begin
          pu[8*j +: 8] = 8'((j[0] ? (255 - u) : u) + 29*j);
          ps[8*j +: 8] = 8'((j[0] ? (s ^ 8'h5A) : s) + 17*j);
        end
        ua_i = pu; sb_i = ps; strobe_i = 1'b1; pend = 1'b1;
      end
    end
    @(negedge clk_i);
    strobe_i = 1'b0;
    check_vec(pu, ps);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule